// File: doc/BRIEF.md
# DMA Channel Enable Register Bank

This block keeps two per-channel bit maps for a DMA controller of 16, 32 or 64 channels. The first is the request enable, which decides whether a peripheral's request line reaches the engine. The second is the error-interrupt enable, which decides whether a channel's error flag raises an interrupt. Software reaches both maps through a simple register port. Each map is split into a high word and a low word of 32 bits. Software can change a map with a whole-word write, or with byte-wide set and clear helper writes that change one chosen channel, or every channel, without a read-modify-write.

The DMA engine reports the end of each channel's major loop on a completion port. When the completed descriptor asks for its request to be disabled, the block drops that channel's request enable by itself. This stops further service until software turns the channel back on. The gated request vector and the per-channel interrupt vector are plain combinational outputs. The register port is control only: a write completes in the cycle it is presented, and read data follows the read address in the same cycle. Neither port has a handshake or back-pressure.

Top module: `dma_chan_enable_bank`

## Requirements
- R1: After reset every request-enable and error-interrupt-enable bit is 0, so `eng_req` and `err_irq` are all 0.
- R2: A write to 0x08 or 0x0C loads request enables for channels 63..32 or 31..0, and 0x10 or 0x14 does the same for error-interrupt enables. Channel n sits at bit n mod 32 of its word. The new value is visible on `rd_data` from the next cycle.
- R3: Bits for channels at or above `NUM_CH` read as 0, and writes to them are ignored.
- R4: `eng_req[n]` equals `per_req[n]` AND request-enable bit n.
- R5: A completion event with `done_dreq`=1 clears the request-enable bit of `done_ch` at the next clock edge. With `done_dreq`=0 the bit keeps its value.
- R6: If a software write and a completion clear target the same request-enable bit in one cycle, the bit ends at 0.
- R7: The set helpers take `wr_data[7:0]`, at 0x18 for request enables and 0x1A for error enables. When bit 6 is 0, bits 5:0 name one channel, and that channel's bit is set while all other bits keep their values. Bit 7 is ignored.
- R8: The clear helpers, at 0x19 for request enables and 0x1B for error enables, clear the named channel's bit in the same way.
- R9: With bit 6 of a helper write set to 1, the set or clear applies to every implemented channel, whatever bits 5:0 hold.
- R10: A helper write with bit 6 at 0 that names a channel at or above `NUM_CH` changes nothing.
- R11: `err_irq[n]` equals `err_flag[n]` AND error-interrupt-enable bit n.
- R12: Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Write data (helpers use bits 7:0) |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Read data for `rd_addr`, same cycle |
| done_valid | input | 1 | Major-loop completion event |
| done_ch | input | 6 | Channel that completed |
| done_dreq | input | 1 | Completed descriptor asks to disable the request |
| per_req | input | NUM_CH | Peripheral request lines |
| eng_req | output | NUM_CH | Requests passed to the engine |
| err_flag | input | NUM_CH | Per-channel error flags |
| err_irq | output | NUM_CH | Per-channel error interrupts |

## Verification
The bench builds the block with `NUM_CH`=16. With that setting, the whole high words and the upper half of each low word fall in the unimplemented range. Every one of the 256 helper byte codes can then be swept against both maps. That one sweep covers single-channel, all-channel, out-of-range and bit-7 cases. The bench also runs completion events on every channel, with and without the disable flag, and races them against word writes and helper writes on the same bit.

// File: rtl/dce_pkg.sv
package dce_pkg;
  localparam int MAX_CH  = 64;
  localparam int WORD_W  = 32;
  localparam int CH_IDX_W = 6;

  localparam logic [7:0] A_REQ_HI = 8'h08;
  localparam logic [7:0] A_REQ_LO = 8'h0C;
  localparam logic [7:0] A_ERR_HI = 8'h10;
  localparam logic [7:0] A_ERR_LO = 8'h14;
  localparam logic [7:0] A_REQ_SET = 8'h18;
  localparam logic [7:0] A_REQ_CLR = 8'h19;
  localparam logic [7:0] A_ERR_SET = 8'h1A;
  localparam logic [7:0] A_ERR_CLR = 8'h1B;

  typedef struct packed {
    logic                word_valid;
    logic                word_hi;
    logic [WORD_W-1:0]   word_data;
    logic                set_valid;
    logic                clr_valid;
    logic                all;
    logic [CH_IDX_W-1:0] sel;
  } map_cmd_t;
endpackage

// File: rtl/dce_decode.sv
module dce_decode
  import dce_pkg::*;
(
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output map_cmd_t          req_cmd,
  output map_cmd_t          err_cmd
);
  always_comb begin
    req_cmd = '0;
    err_cmd = '0;
    req_cmd.word_data = wr_data;
    err_cmd.word_data = wr_data;
    req_cmd.all = wr_data[6];
    err_cmd.all = wr_data[6];
    req_cmd.sel = wr_data[CH_IDX_W-1:0];
    err_cmd.sel = wr_data[CH_IDX_W-1:0];
    if (wr_en) begin
      unique case (wr_addr)
        A_REQ_HI:  begin req_cmd.word_valid = 1'b1; req_cmd.word_hi = 1'b1; end
        A_REQ_LO:  req_cmd.word_valid = 1'b1;
        A_ERR_HI:  begin err_cmd.word_valid = 1'b1; err_cmd.word_hi = 1'b1; end
        A_ERR_LO:  err_cmd.word_valid = 1'b1;
        A_REQ_SET: req_cmd.set_valid = 1'b1;
        A_REQ_CLR: req_cmd.clr_valid = 1'b1;
        A_ERR_SET: err_cmd.set_valid = 1'b1;
        A_ERR_CLR: err_cmd.clr_valid = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dce_bitmap.sv
module dce_bitmap
  import dce_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  map_cmd_t            cmd,
  input  logic                hw_clr_valid,
  input  logic [CH_IDX_W-1:0] hw_clr_ch,
  output logic [NUM_CH-1:0]   q,
  output logic [MAX_CH-1:0]   q64
);
  logic [NUM_CH-1:0] q_nxt;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam logic [CH_IDX_W-1:0] ID = CH_IDX_W'(n);
    localparam int BIT_POS = n % WORD_W;
    localparam logic IN_HI = (n >= WORD_W);
    always_comb begin
      q_nxt[n] = q[n];
      if (cmd.word_valid && (cmd.word_hi == IN_HI))
        q_nxt[n] = cmd.word_data[BIT_POS];
      if (cmd.set_valid && (cmd.all || cmd.sel == ID))
        q_nxt[n] = 1'b1;
      if (cmd.clr_valid && (cmd.all || cmd.sel == ID))
        q_nxt[n] = 1'b0;
      if (hw_clr_valid && hw_clr_ch == ID)
        q_nxt[n] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  if (NUM_CH == MAX_CH) begin : g_full
    assign q64 = q;
  end else begin : g_pad
    assign q64 = {{(MAX_CH-NUM_CH){1'b0}}, q};
  end

  localparam logic [CH_IDX_W:0] LIMIT = (CH_IDX_W+1)'(NUM_CH);

  p_hw_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr_valid && {1'b0, hw_clr_ch} < LIMIT) |=> !q64[$past(hw_clr_ch)]);

  p_set_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.set_valid && !cmd.all && {1'b0, cmd.sel} < LIMIT &&
     !(hw_clr_valid && hw_clr_ch == cmd.sel)) |=> q64[$past(cmd.sel)]);

  p_clr_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.clr_valid && {1'b0, cmd.sel} < LIMIT) |=> !q64[$past(cmd.sel)]);

  p_clr_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.clr_valid && cmd.all) |=> (q == '0));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.word_valid && !cmd.set_valid && !cmd.clr_valid && !hw_clr_valid)
    |=> $stable(q));
endmodule

// File: rtl/dce_readmux.sv
module dce_readmux
  import dce_pkg::*;
(
  input  logic [7:0]        rd_addr,
  input  logic [MAX_CH-1:0] req64,
  input  logic [MAX_CH-1:0] err64,
  output logic [WORD_W-1:0] rd_data
);
  always_comb begin
    unique case (rd_addr)
      A_REQ_HI: rd_data = req64[MAX_CH-1:WORD_W];
      A_REQ_LO: rd_data = req64[WORD_W-1:0];
      A_ERR_HI: rd_data = err64[MAX_CH-1:WORD_W];
      A_ERR_LO: rd_data = err64[WORD_W-1:0];
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dce_gate.sv
module dce_gate #(
  parameter int W = 64
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] en,
  output logic [W-1:0] dst
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dst[i] = src[i] & en[i];
  end
endmodule

// File: rtl/dma_chan_enable_bank.sv
module dma_chan_enable_bank
  import dce_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [7:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic              done_valid,
  input  logic [5:0]        done_ch,
  input  logic              done_dreq,
  input  logic [NUM_CH-1:0] per_req,
  output logic [NUM_CH-1:0] eng_req,
  input  logic [NUM_CH-1:0] err_flag,
  output logic [NUM_CH-1:0] err_irq
);
  initial begin
    assert (NUM_CH == 16 || NUM_CH == 32 || NUM_CH == 64)
      else $error("NUM_CH must be 16, 32 or 64");
  end

  map_cmd_t          req_cmd, err_cmd;
  logic [NUM_CH-1:0] req_q, err_q;
  logic [MAX_CH-1:0] req64, err64;
  logic              auto_clr;

  assign auto_clr = done_valid & done_dreq;

  dce_decode u_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_cmd(req_cmd), .err_cmd(err_cmd)
  );

  dce_bitmap #(.NUM_CH(NUM_CH)) u_req_map (
    .clk(clk), .rst_n(rst_n), .cmd(req_cmd),
    .hw_clr_valid(auto_clr), .hw_clr_ch(done_ch),
    .q(req_q), .q64(req64)
  );

  dce_bitmap #(.NUM_CH(NUM_CH)) u_err_map (
    .clk(clk), .rst_n(rst_n), .cmd(err_cmd),
    .hw_clr_valid(1'b0), .hw_clr_ch('0),
    .q(err_q), .q64(err64)
  );

  dce_readmux u_rd (
    .rd_addr(rd_addr), .req64(req64), .err64(err64), .rd_data(rd_data)
  );

  dce_gate #(.W(NUM_CH)) u_req_gate (.src(per_req),  .en(req_q), .dst(eng_req));
  dce_gate #(.W(NUM_CH)) u_irq_gate (.src(err_flag), .en(err_q), .dst(err_irq));

  p_req_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req & ~per_req) == '0);

  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq & ~err_flag) == '0);

  p_hw_beats_sw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_clr && wr_en && wr_addr == A_REQ_SET && done_ch == wr_data[5:0] &&
     {1'b0, done_ch} < 7'(NUM_CH)) |=> !req64[$past(done_ch)]);
endmodule

// File: tb/test_dma_chan_enable_bank.sv
`timescale 1ns/1ps
module test_dma_chan_enable_bank;
  localparam int N = 16;
  localparam logic [63:0] MASK = (64'd1 << N) - 64'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [7:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic        done_valid = 0;
  logic [5:0]  done_ch = 0;
  logic        done_dreq = 0;
  logic [N-1:0] per_req = 0, eng_req, err_flag = 0, err_irq;

  dma_chan_enable_bank #(.NUM_CH(N)) i_dma_chan_enable_bank (.*);

  int n_chk = 0, n_fail = 0;
  logic [63:0] erq_m = 0, eei_m = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic check_regs(string tag);
    logic [31:0] d;
    rd(8'h08, d); chk({tag, " req hi"}, 64'(d), 64'(erq_m[63:32]));
    rd(8'h0C, d); chk({tag, " req lo"}, 64'(d), 64'(erq_m[31:0]));
    rd(8'h10, d); chk({tag, " err hi"}, 64'(d), 64'(eei_m[63:32]));
    rd(8'h14, d); chk({tag, " err lo"}, 64'(d), 64'(eei_m[31:0]));
  endtask

  function automatic logic [63:0] helper(logic [63:0] m, logic [7:0] c, bit set);
    logic [63:0] r = m;
    if (c[6]) r = set ? MASK : 64'd0;
    else if (int'(c[5:0]) < N) r[c[5:0]] = set;
    return r;
  endfunction

  task automatic cycle(bit we, logic [7:0] a, logic [31:0] d,
                       bit dv, logic [5:0] dc, bit dq);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    done_valid = dv; done_ch = dc; done_dreq = dq;
    @(negedge clk);
    wr_en = 0; done_valid = 0;
    if (we) begin
      case (a)
        8'h08: erq_m[63:32] = d;
        8'h0C: erq_m[31:0]  = d;
        8'h10: eei_m[63:32] = d;
        8'h14: eei_m[31:0]  = d;
        8'h18: erq_m = helper(erq_m, d[7:0], 1);
        8'h19: erq_m = helper(erq_m, d[7:0], 0);
        8'h1A: eei_m = helper(eei_m, d[7:0], 1);
        8'h1B: eei_m = helper(eei_m, d[7:0], 0);
        default: ;
      endcase
    end
    if (dv && dq) erq_m[dc] = 1'b0;
    erq_m &= MASK;
    eei_m &= MASK;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cycle(1, a, d, 0, 0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] pats [4] = '{32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0000_8001, 32'h1234_5678};
    repeat (3) @(negedge clk);
    // R1 reset state
    check_regs("R1");
    per_req = '1; err_flag = '1; #0.5;
    chk("R1 eng_req", 64'(eng_req), 0);
    chk("R1 err_irq", 64'(err_irq), 0);
    rst_n = 1'b1;

    // R2 / R3 word writes
    foreach (pats[i]) begin
      wr(8'h08, pats[i]); wr(8'h0C, ~pats[i]);
      wr(8'h10, pats[i] ^ 32'h0F0F_0F0F); wr(8'h14, pats[i]);
      check_regs("R2 R3");
    end

    // R12 other addresses
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h1C, 32'h0000_0040); wr(8'h0D, 32'hFFFF_FFFF);
    check_regs("R12 write");
    rd(8'h04, d); chk("R12 read", 64'(d), 0);
    rd(8'h1A, d); chk("R12 read helper", 64'(d), 0);

    // R7 R8 R9 R10 helper sweep over every byte code
    for (int c = 0; c < 256; c++) begin
      wr(8'h18, 32'h40); wr(8'h19, 32'(c)); check_regs("R8 R9 R10 req clr");
      wr(8'h19, 32'h40); wr(8'h18, 32'(c)); check_regs("R7 R9 R10 req set");
      wr(8'h1A, 32'h40); wr(8'h1B, 32'(c)); check_regs("R8 R9 R10 err clr");
      wr(8'h1B, 32'h40); wr(8'h1A, 32'(c)); check_regs("R7 R9 R10 err set");
    end

    // R4 R11 gating
    for (int e = 0; e < 8; e++) begin
      wr(8'h0C, 32'(e * 16'h2493 + 16'h1111));
      wr(8'h14, 32'(e * 16'h3A5B + 16'h0F0F));
      for (int p = 0; p < 16; p++) begin
        per_req = N'(p * 16'h1357 + 16'h00FF);
        err_flag = N'(p * 16'h2F19 + 16'hF000);
        #0.5;
        chk("R4 eng_req", 64'(eng_req), 64'(per_req) & erq_m);
        chk("R11 err_irq", 64'(err_irq), 64'(err_flag) & eei_m);
      end
    end

    // R5 completion clears
    for (int ch = 0; ch < 24; ch++) begin
      wr(8'h18, 32'h40);
      cycle(0, 0, 0, 1, 6'(ch), 0); check_regs("R5 dreq0");
      cycle(0, 0, 0, 1, 6'(ch), 1); check_regs("R5 dreq1");
    end

    // R6 hardware clear beats software write
    wr(8'h0C, 32'h0);
    cycle(1, 8'h0C, 32'hFFFF_FFFF, 1, 6'd3, 1);
    check_regs("R6 word");
    wr(8'h19, 32'h40);
    cycle(1, 8'h18, 32'h07, 1, 6'd7, 1);
    check_regs("R6 helper");
    cycle(1, 8'h18, 32'h40, 1, 6'd15, 1);
    check_regs("R6 all");

    finished = 1;
    summary();
  end
endmodule